// File: doc/BRIEF.md
# GPIO Edge Interrupt Latch

This block watches eight general-purpose input pins, arranged as two ports of four pins each, and records level changes on them as interrupt requests. Each pin has two stored bits. The first is a remembered level, called the old value. The second is a pending flag, called the interrupt state. Each pin input passes through a two-flop synchroniser. When the synchronised level differs from the old value, the pending flag is set. It then stays set until software acknowledges it.

Software sees the block through one 32-bit control and status word. The bottom half of the word is read-only. It shows the pending flags and the old values. The top half holds write-only command bits that load the old value to 1 or to 0. Either command also clears the pending flag. To acknowledge an edge, software writes the level it now expects. The direction of an edge follows from the old value of a pending pin: 0 means the pin went high, and 1 means it went low.

A separate 8-bit enable register selects which pending flags drive the single event output.

Top module: `gpio_edge_latch`

## Requirements
- R1: After a synchronous reset, the whole status word, the enable register and the event output all read 0.
- R2: A level change on a pin is first visible in the pending flag on the third rising clock edge after the change. This delay comes from two synchroniser stages plus the flag register.
- R3: Pin index i is port*4 + pin. Writing 1 to status word bit 16+i loads old value bit i (word bit 8+i) with 1. Writing 1 to bit 24+i loads it with 0. If both bits are written for the same pin, the load to 1 takes effect. When no command bit is written for a pin, its old value does not change.
- R4: A command bit written for a pin clears that pin's pending flag (word bit i) on the same edge. If the synchronised level still differs from the new old value, the flag sets again on the next edge.
- R5: A pending flag stays set after the pin returns to its old level, and remains set until a command is written for that pin.
- R6: While a pin's pending flag is set, an old value of 0 marks a low-to-high edge and an old value of 1 marks a high-to-low edge.
- R7: Writes to status word bits 15:0 have no effect. Bits 31:16 always read back as 0.
- R8: Enable register bit i selects pin i (bits 3:0 are port 0, bits 7:4 are port 1). The enable register is loaded one edge after its write strobe. The event output is combinationally the OR of the pending flags ANDed with the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous pin levels, index port*4+pin |
| ctl_wr | input | 1 | Write strobe for the status word |
| ctl_wdata | input | 32 | Status word write data (command bits in 31:16) |
| ctl_rdata | output | 32 | Status word read data |
| evt_en_wr | input | 1 | Write strobe for the enable register |
| evt_en_wdata | input | 8 | Enable register write data |
| evt_en_q | output | 8 | Current enable register value |
| evt_out | output | 1 | Event request, OR of enabled pending flags |

## Verification
A pin change is due in the pending flag on the third edge after it is driven. Command writes and enable writes take effect on the edge that captures them. The read word and the event output follow the registers combinationally within the same cycle. The bench drives every input 2 ns after a rising edge and samples all outputs at that same point. As a result, each check reads exactly the registers updated by the edge just passed. A cycle-level model built from the requirements advances once per edge. Directed checks compare against literal values at the first, second and third edge after a pin change, to pin down the latency.

// File: rtl/gpio_edge_pkg.sv
// Package: shared field layout of the status word.
// Assumes the word is four equal fields of one bit per pin.
package gpio_edge_pkg;

    // Field index inside the status word, lowest field first.
    typedef enum logic [1:0] {
        FLD_STATE = 2'd0,
        FLD_OLD   = 2'd1,
        FLD_SET   = 2'd2,
        FLD_CLR   = 2'd3
    } field_e;

    localparam int unsigned FIELD_COUNT = 4;

    // Base bit of a field for a given pin count.
    function automatic int unsigned field_base(field_e f, int unsigned npins);
        return int'(f) * npins;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage flop synchroniser for a bus of independent bits.
// Assumes each bit is an unrelated level; no bus coherency is implied.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the sampled levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_track.sv
// Module: per-pin old-value and pending-flag tracker.
// Assumes level is already synchronised; set_cmd wins over clr_cmd.
module gpio_pin_track (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic set_cmd,
    input  logic clr_cmd,
    output logic old_q,
    output logic state_q
);

    // Load the remembered level from software commands.
    always_ff @(posedge clk) begin
        if (!rst_n)       old_q <= 1'b0;
        else if (set_cmd) old_q <= 1'b1;
        else if (clr_cmd) old_q <= 1'b0;
    end

    // Raise the sticky pending flag on mismatch; drop it on any command.
    always_ff @(posedge clk) begin
        if (!rst_n)                  state_q <= 1'b0;
        else if (set_cmd || clr_cmd) state_q <= 1'b0;
        else if (level != old_q)     state_q <= 1'b1;
    end

endmodule

// File: rtl/gpio_event_gate.sv
// Module: enable register and masked OR of pending flags.
// Assumes the enable register is written as a whole byte.
module gpio_event_gate #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [NPINS-1:0] en_wdata,
    input  logic [NPINS-1:0] state,
    output logic [NPINS-1:0] en_q,
    output logic             event_o
);

    // Hold the per-pin event enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // Combine enabled pending flags into one request.
    always_comb event_o = |(state & en_q);

endmodule

// File: rtl/gpio_edge_latch.sv
// Module: top of the edge interrupt latch for NUM_PORTS x PINS_PER_PORT pins.
// Assumes pin index = port*PINS_PER_PORT + pin and a single write strobe.
module gpio_edge_latch
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PORTS     = 2,
    parameter int PINS_PER_PORT = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]        pin_in,
    input  logic                                      ctl_wr,
    input  logic [FIELD_COUNT*NUM_PORTS*PINS_PER_PORT-1:0] ctl_wdata,
    output logic [FIELD_COUNT*NUM_PORTS*PINS_PER_PORT-1:0] ctl_rdata,
    input  logic                                      evt_en_wr,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]        evt_en_wdata,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]        evt_en_q,
    output logic                                      evt_out
);

    localparam int NPINS    = NUM_PORTS * PINS_PER_PORT;
    localparam int STATE_LO = field_base(FLD_STATE, NPINS);
    localparam int OLD_LO   = field_base(FLD_OLD, NPINS);
    localparam int SET_LO   = field_base(FLD_SET, NPINS);
    localparam int CLR_LO   = field_base(FLD_CLR, NPINS);

    logic [NPINS-1:0] level;
    logic [NPINS-1:0] set_cmd;
    logic [NPINS-1:0] clr_cmd;
    logic [NPINS-1:0] old_vec;
    logic [NPINS-1:0] state_vec;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (level)
    );

    // Split the write into per-pin commands, gated by the strobe.
    always_comb begin
        set_cmd = ctl_wr ? ctl_wdata[SET_LO +: NPINS] : '0;
        clr_cmd = ctl_wr ? ctl_wdata[CLR_LO +: NPINS] : '0;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .level   (level[i]),
            .set_cmd (set_cmd[i]),
            .clr_cmd (clr_cmd[i]),
            .old_q   (old_vec[i]),
            .state_q (state_vec[i])
        );
    end

    gpio_event_gate #(.NPINS(NPINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (evt_en_wr),
        .en_wdata (evt_en_wdata),
        .state    (state_vec),
        .en_q     (evt_en_q),
        .event_o  (evt_out)
    );

    // Assemble the read word; command fields read as zero.
    always_comb begin
        ctl_rdata                      = '0;
        ctl_rdata[OLD_LO +: NPINS]     = old_vec;
        ctl_rdata[STATE_LO +: NPINS]   = state_vec;
    end

endmodule

// File: rtl/gpio_edge_latch_chk.sv
// Module: property checker for gpio_edge_latch, attached by bind.
// Assumes the default field order of gpio_edge_pkg.
module gpio_edge_latch_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PORTS     = 2,
    parameter int PINS_PER_PORT = 4
) (
    input logic                                           clk,
    input logic                                           rst_n,
    input logic                                           ctl_wr,
    input logic [FIELD_COUNT*NUM_PORTS*PINS_PER_PORT-1:0] ctl_wdata,
    input logic [FIELD_COUNT*NUM_PORTS*PINS_PER_PORT-1:0] ctl_rdata,
    input logic                                           evt_en_wr,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]             evt_en_wdata,
    input logic [NUM_PORTS*PINS_PER_PORT-1:0]             evt_en_q,
    input logic                                           evt_out
);

    localparam int N = NUM_PORTS * PINS_PER_PORT;

    logic [N-1:0] w_set, w_clr, r_old, r_st;
    assign w_set = ctl_wr ? ctl_wdata[2*N +: N] : '0;
    assign w_clr = ctl_wr ? ctl_wdata[3*N +: N] : '0;
    assign r_old = ctl_rdata[N +: N];
    assign r_st  = ctl_rdata[0 +: N];

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_rdata == '0) && (evt_en_q == '0) && !evt_out);

    p_set_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_old & $past(w_set)) == $past(w_set)));

    p_clr_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_old & ($past(w_clr) & ~$past(w_set))) == '0));

    p_old_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(r_old));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_st & ($past(w_set) | $past(w_clr))) == '0));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ((r_st & $past(r_st)) == $past(r_st)));

    p_cmd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4*N-1:2*N] == '0);

    p_enable_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_en_wr |=> (evt_en_q == $past(evt_en_wdata)));

    p_event_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out == (|(r_st & evt_en_q)));

endmodule

bind gpio_edge_latch gpio_edge_latch_chk #(
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .ctl_rdata    (ctl_rdata),
    .evt_en_wr    (evt_en_wr),
    .evt_en_wdata (evt_en_wdata),
    .evt_en_q     (evt_en_q),
    .evt_out      (evt_out)
);

// File: tb/sim_gpio_edge_latch.sv
// Bench: directed latency checks plus a sweep of all 256 pin patterns.
module sim_gpio_edge_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        cw_en = 1'b0;
    logic [31:0] cw_data = '0;
    logic        ee_wr = 1'b0;
    logic [7:0]  ee_data = '0;
    logic [31:0] stat;
    logic [7:0]  ee_q;
    logic        evt;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Requirement model state
    logic [7:0] m_s1 = '0, m_s2 = '0, m_old = '0, m_st = '0, m_ee = '0;

    always #10 clk = ~clk;

    gpio_edge_latch u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pins),
        .ctl_wr       (cw_en),
        .ctl_wdata    (cw_data),
        .ctl_rdata    (stat),
        .evt_en_wr    (ee_wr),
        .evt_en_wdata (ee_data),
        .evt_en_q     (ee_q),
        .evt_out      (evt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One edge; the model advances from the inputs held across it.
    task automatic tick();
        logic [7:0] sv, cv, nold, nst;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_old = '0; m_st = '0; m_ee = '0;
        end else begin
            sv   = cw_en ? cw_data[23:16] : 8'h00;
            cv   = cw_en ? cw_data[31:24] : 8'h00;
            nold = sv | (m_old & ~cv);
            nst  = ~(sv | cv) & (m_st | (m_s2 ^ m_old));
            m_s2 = m_s1; m_s1 = pins; m_old = nold; m_st = nst;
            if (ee_wr) m_ee = ee_data;
        end
        #2;
    endtask

    task automatic wr(logic [31:0] d);
        cw_en = 1'b1; cw_data = d;
        tick();
        cw_en = 1'b0; cw_data = '0;
    endtask

    task automatic cmp_model(string tag);
        chk(tag, stat, {16'h0000, m_old, m_st});
        chk(tag, {31'd0, evt}, {31'd0, |(m_st & m_ee)});
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 word", stat, 32'h0);
        chk("R1 enable", {24'd0, ee_q}, 32'h0);
        chk("R1 event", {31'd0, evt}, 32'h0);
        rst_n = 1'b1;
        repeat (2) tick();
        cmp_model("R1 idle");

        // R2: pin 0 rises, flag due on third edge
        pins = 8'h01;
        tick(); chk("R2 edge1", stat, 32'h0);
        tick(); chk("R2 edge2", stat, 32'h0);
        tick(); chk("R2 edge3", stat, 32'h0000_0001);
        // R6: old 0 with flag set means rising
        chk("R6 rising", {31'd0, stat[8]}, 32'h0);

        // R4: acknowledge with set command
        wr(32'h0001_0000);
        chk("R4 ack", stat, 32'h0000_0100);
        tick(); chk("R4 quiet", stat, 32'h0000_0100);

        // R6: falling edge on pin 0
        pins = 8'h00;
        repeat (3) tick();
        chk("R6 falling", stat, 32'h0000_0101);

        // R4: wrong acknowledge, flag re-arms next edge
        wr(32'h0001_0000);
        chk("R4 cleared", stat, 32'h0000_0100);
        tick(); chk("R4 rearm", stat, 32'h0000_0101);

        // R3: clear command loads 0
        wr(32'h0100_0000);
        chk("R3 clear", stat, 32'h0);
        tick(); chk("R3 settled", stat, 32'h0);

        // R3: set and clear together on pin 3, set wins
        wr(32'h0808_0000);
        chk("R3 both", stat, 32'h0000_0800);
        tick(); chk("R3 both rearm", stat, 32'h0000_0808);
        wr(32'h0800_0000);
        tick(); chk("R3 restore", stat, 32'h0);

        // R7: writes to read-only fields ignored
        wr(32'h0000_FFFF);
        chk("R7 ro", stat, 32'h0);
        tick(); chk("R7 ro hold", stat, 32'h0);

        // R5: short pulse on pin 5 stays pending
        pins = 8'h20; tick(); pins = 8'h00;
        repeat (6) tick();
        chk("R5 sticky", stat, 32'h0000_0020);

        // R8: enable mapping and event
        chk("R8 masked", {31'd0, evt}, 32'h0);
        ee_wr = 1'b1; ee_data = 8'h20; tick(); ee_wr = 1'b0;
        chk("R8 en load", {24'd0, ee_q}, 32'h20);
        chk("R8 event on", {31'd0, evt}, 32'h1);
        ee_wr = 1'b1; ee_data = 8'h10; tick(); ee_wr = 1'b0;
        chk("R8 other pin", {31'd0, evt}, 32'h0);
        wr(32'h2000_0000);
        chk("R5 ack", stat, 32'h0);
        ee_wr = 1'b1; ee_data = 8'hFF; tick(); ee_wr = 1'b0;

        // R3 R4 R8: sweep every pin pattern
        for (int p = 0; p < 256; p++) begin
            pins = p[7:0];
            repeat (3) tick();
            cmp_model("R2 sweep");
            wr({~p[7:0], p[7:0], 16'h0000});
            chk("R3 sweep", stat, {16'h0000, p[7:0], 8'h00});
            tick();
            cmp_model("R4 sweep");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule